// File: doc/BRIEF.md
# Command-Queue I2C Bus Master

This block is an I2C bus master that works through a stream of 11-bit command words. Each word moves one byte on the bus. It says whether the byte is written or read, and it can ask for a repeated START before the byte or a STOP after it. Software never programs a transfer length. It builds a transaction by queuing one word per byte. When the queue runs dry before a STOP has been requested, the engine keeps ownership of the bus by holding SCL low. It then waits for the next word.

The first word after idle opens the transaction. The engine sends START and then the address byte. The address byte carries the 7-bit target address, with the direction taken from the word's read flag. The bit timing comes from a selectable pair of SCL high and low counts: one pair for standard speed and one for fast speed. A programmable hold sets when SDA moves after SCL falls. Read bytes leave through a ready/valid receive port. Failures set bits in a sticky abort vector, and while that vector is nonzero, incoming words are swallowed. The enable request is applied only between transactions, and the applied value is reported back on `en_status`.

Top module: `i2c_cmd_master`

## Requirements
- R1: A command word is decoded as follows: bits 7:0 hold the byte to write, bit 8 = 1 reads a byte instead, bit 9 = 1 ends the transaction with STOP after this byte, and bit 10 = 1 puts a repeated START and a fresh address byte before this byte.
- R2: A word accepted while idle produces START and then the address byte {target_addr, bit 8 of the word}, followed by the data byte. Every byte is sent MSB first, and the 9th clock samples ACK (SDA low).
- R3: A read byte is acknowledged (SDA driven low on the 9th clock) unless its word has bit 9 set, in which case it is not acknowledged. The received byte appears on `rx_data` with `rx_valid` and is held stable until `rx_ready`.
- R4: After a byte whose word lacks the STOP flag, `busy` stays 1 and SCL stays low. The next word continues the same transaction with no new START.
- R5: A word with bit 10 set, accepted while the bus is held, causes a repeated START and a new address byte whose direction comes from that word's bit 8.
- R6: Inside a byte, every SCL low period lasts exactly the low count and every SCL high period lasts exactly the high count of the pair selected by `fast_mode` (0 = standard pair, 1 = fast pair).
- R7: A data bit on SDA changes sda_hold+1 clock cycles after SCL is pulled low.
- R8: `en_status` takes the value of `enable_req` one cycle later, but only while not busy. A disable request made during a transaction takes effect after that transaction ends. `cmd_ready` is 0 while `en_status` is 0.
- R9: After reset: `busy`=0, `en_status`=0, `abort_src`=0, `cmd_ready`=0, and both bus lines are released.
- R10: An address byte without ACK sets `abort_src` bit 0, and a written data byte without ACK sets bit 3. Either failure is followed by a STOP.
- R11: Reading SDA low while driving a 1 during an address or write bit sets `abort_src` bit 12. Both lines are released at once and no STOP is driven.
- R12: While `abort_src` is nonzero, words are accepted and discarded with no bus activity. Bits stay set until `abort_clr`, which zeroes the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_req | input | 1 | Requested enable state |
| en_status | output | 1 | Enable state actually applied |
| fast_mode | input | 1 | 1 selects the fast count pair |
| target_addr | input | 7 | Target address for address bytes |
| std_hi_cnt | input | CW | SCL high cycles, standard speed |
| std_lo_cnt | input | CW | SCL low cycles, standard speed |
| fast_hi_cnt | input | CW | SCL high cycles, fast speed |
| fast_lo_cnt | input | CW | SCL low cycles, fast speed |
| sda_hold | input | CW | SDA hold after SCL fall, minus one cycle |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word taken this cycle |
| cmd_word | input | 11 | Command word |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Receiver takes the byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress or bus held |
| abort_src | output | 13 | Sticky failure vector |
| abort_clr | input | 1 | Clears the failure vector |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
The assertions assume three things about the inputs: every count is at least 2, sda_hold+1 is smaller than the selected low count, and the count and speed inputs stay constant while `busy` is high. They also assume that no other device stretches SCL. The stimulus sets all timing inputs during reset. It changes `fast_mode` only between transactions, when `busy` is low, and uses counts well inside these limits for both speeds. The target model on the bench only acknowledges and supplies data on SDA. The one contention case is a deliberate SDA jam, used to provoke arbitration loss.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_req,
  output logic          en_status,
  input  logic          fast_mode,
  input  logic [6:0]    target_addr,
  input  logic [CW-1:0] std_hi_cnt,
  input  logic [CW-1:0] std_lo_cnt,
  input  logic [CW-1:0] fast_hi_cnt,
  input  logic [CW-1:0] fast_lo_cnt,
  input  logic [CW-1:0] sda_hold,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [10:0]   cmd_word,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [7:0]    rx_data,
  output logic          busy,
  output logic [12:0]   abort_src,
  input  logic          abort_clr,
  output logic          scl_oe,
  input  logic          scl_in,
  output logic          sda_oe,
  input  logic          sda_in
);
  typedef enum logic [3:0] {IDLE, HOLD, START, RS_LO, RS_HI, B_LO, B_HI, PUSH, P_LO, P_HI, P_END} st_t;

  st_t st;
  logic [CW-1:0] tmr;
  logic [8:0]    sh;
  logic [3:0]    bidx;
  logic [9:0]    cq;
  logic          is_addr;

  wire [CW-1:0] hcnt = fast_mode ? fast_hi_cnt : std_hi_cnt;
  wire [CW-1:0] lcnt = fast_mode ? fast_lo_cnt : std_lo_cnt;
  wire h_end   = tmr == hcnt - CW'(1);
  wire l_end   = tmr == lcnt - CW'(1);
  wire at_hold = tmr == sda_hold;
  wire tx_byte = is_addr || !cq[8];

  assign busy      = st != IDLE;
  assign cmd_ready = en_status && (st == IDLE || st == HOLD);
  wire take = cmd_valid && cmd_ready;
  wire go   = take && st == IDLE && abort_src == '0;

  function automatic logic [8:0] load(input logic [9:0] c);
    load = c[8] ? {8'hFF, c[9]} : {c[7:0], 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; tmr <= '0; sh <= '0; bidx <= '0; cq <= '0; is_addr <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; en_status <= 1'b0;
      abort_src <= '0; rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      tmr <= tmr + CW'(1);
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (abort_clr) abort_src <= '0;
      if (st == IDLE && !go) en_status <= enable_req;
      case (st)
        IDLE: if (go) begin
          cq <= cmd_word[9:0]; st <= START; sda_oe <= 1'b1; tmr <= '0;
        end
        HOLD: if (take) begin
          cq <= cmd_word[9:0]; tmr <= '0;
          if (cmd_word[10]) st <= RS_LO;
          else begin st <= B_LO; sh <= load(cmd_word[9:0]); bidx <= '0; is_addr <= 1'b0; end
        end
        START: if (h_end) begin
          st <= B_LO; scl_oe <= 1'b1; tmr <= '0;
          sh <= {target_addr, cq[8], 1'b1}; bidx <= '0; is_addr <= 1'b1;
        end
        RS_LO: begin
          if (at_hold) sda_oe <= 1'b0;
          if (l_end) begin st <= RS_HI; scl_oe <= 1'b0; tmr <= '0; end
        end
        RS_HI: if (h_end) begin st <= START; sda_oe <= 1'b1; tmr <= '0; end
        B_LO: begin
          if (at_hold) sda_oe <= ~sh[8];
          if (l_end) begin st <= B_HI; scl_oe <= 1'b0; tmr <= '0; end
        end
        B_HI: if (!scl_in) tmr <= '0;
        else if (h_end) begin
          sh <= {sh[7:0], sda_in}; bidx <= bidx + 4'd1; scl_oe <= 1'b1; tmr <= '0;
          if (tx_byte && bidx < 4'd8 && sh[8] && !sda_in) begin
            abort_src[12] <= 1'b1; scl_oe <= 1'b0; sda_oe <= 1'b0; st <= IDLE;
          end else if (bidx != 4'd8) st <= B_LO;
          else if (is_addr) begin
            if (sda_in) begin abort_src[0] <= 1'b1; st <= P_LO; end
            else begin st <= B_LO; sh <= load(cq); bidx <= '0; is_addr <= 1'b0; end
          end else if (cq[8]) st <= PUSH;
          else if (sda_in) begin abort_src[3] <= 1'b1; st <= P_LO; end
          else st <= cq[9] ? P_LO : HOLD;
        end
        PUSH: if (!rx_valid || rx_ready) begin
          rx_data <= sh[8:1]; rx_valid <= 1'b1; tmr <= '0;
          st <= cq[9] ? P_LO : HOLD;
        end
        P_LO: begin
          if (at_hold) sda_oe <= 1'b1;
          if (l_end) begin st <= P_HI; scl_oe <= 1'b0; tmr <= '0; end
        end
        P_HI:  if (h_end) begin st <= P_END; sda_oe <= 1'b0; tmr <= '0; end
        P_END: if (h_end) begin st <= IDLE; tmr <= '0; end
        default: st <= IDLE;
      endcase
    end
  end

  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  // R8
  en_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(en_status));
  // R8
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_status |-> !busy);
  // R12
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_clr |=> ((abort_src & $past(abort_src)) == $past(abort_src)));
  // R11
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_src[12]) |-> !scl_oe && !sda_oe);
endmodule

// File: tb/tb_i2c_cmd_master.sv
`timescale 1ns/1ps
module tb_i2c_cmd_master;
  localparam int CW = 16;
  localparam logic [6:0] SLV = 7'h2A;
  localparam int SH = 5, SL = 7, SD = 3, FH = 3, FL = 4, FD = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable_req = 1'b0, fast_mode = 1'b0;
  logic [6:0] target_addr = SLV;
  logic cmd_valid = 1'b0, rx_ready = 1'b1, abort_clr = 1'b0;
  logic [10:0] cmd_word = '0;
  logic en_status, cmd_ready, rx_valid, busy, scl_oe, sda_oe;
  logic [7:0] rx_data;
  logic [12:0] abort_src;
  logic s_pull = 1'b0, jam = 1'b0;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | s_pull | jam);

  always #2 clk = ~clk;

  i2c_cmd_master #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .enable_req(enable_req), .en_status(en_status),
    .fast_mode(fast_mode), .target_addr(target_addr),
    .std_hi_cnt(CW'(SH)), .std_lo_cnt(CW'(SL)), .fast_hi_cnt(CW'(FH)), .fast_lo_cnt(CW'(FL)),
    .sda_hold(fast_mode ? CW'(FD) : CW'(SD)),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .busy(busy),
    .abort_src(abort_src), .abort_clr(abort_clr),
    .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line));

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [7:0] pat(input int k);
    pat = 8'h3C + 8'(k * 29);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // target model
  int ph = 0, cnt = 0, wn = 0, rn = 0, start_cnt = 0, stop_cnt = 0;
  logic [7:0] sr = '0, rbyte = '0;
  logic ackbit = 1'b0, rw = 1'b0, ps = 1'b1, pd = 1'b1;
  logic [7:0] wlog [0:63];
  logic mack [0:63];
  always @(negedge clk) begin
    if (!rst_n) begin ph = 0; cnt = 0; s_pull = 1'b0; end
    else if (ps && scl_line && pd && !sda_line) begin ph = 1; cnt = 0; s_pull = 1'b0; start_cnt++; end
    else if (ps && scl_line && !pd && sda_line) begin ph = 0; s_pull = 1'b0; stop_cnt++; end
    else if (!ps && scl_line && ph != 0) begin
      if (cnt < 8) sr = {sr[6:0], sda_line}; else ackbit = sda_line;
      cnt++;
    end else if (ps && !scl_line && ph != 0) begin
      if (cnt == 8) begin
        if (ph == 1) begin
          rw = sr[0]; s_pull = (sr[7:1] == SLV);
          if (sr[7:1] != SLV) ph = 0;
        end else if (ph == 2) begin
          if (wn < 64) wlog[wn] = sr;
          wn++; s_pull = (sr != 8'hEE);
        end else s_pull = 1'b0;
      end else if (cnt == 9) begin
        cnt = 0;
        if (ph == 1) ph = rw ? 3 : 2;
        else if (ph == 3) begin
          if (rn > 0 && rn <= 64) mack[rn-1] = ackbit;
          if (ackbit) ph = 0;
        end
        if (ph == 3) begin rbyte = pat(rn); rn++; s_pull = ~rbyte[7]; end
        else s_pull = 1'b0;
      end else if (ph == 3) s_pull = ~rbyte[7-cnt];
    end
    ps = scl_line; pd = sda_line;
  end

  // receive capture and timing monitor
  logic [7:0] rlog [0:63];
  int rcv = 0;
  int seg = 9, run = 0, hold_meas = -1;
  int wseg [0:3];
  bit hold_got = 1'b0;
  logic mps = 1'b1, mpd = 1'b1;
  always @(negedge clk) begin
    if (rx_valid && rx_ready) begin
      if (rcv < 64) rlog[rcv] = rx_data;
      rcv++;
    end
    if (scl_line != mps) begin
      if (seg < 4) wseg[seg] = run;
      seg++; run = 1;
    end else run++;
    if (!scl_line && sda_line != mpd && seg == 3 && !hold_got) begin hold_meas = run - 1; hold_got = 1'b1; end
    if (mps && scl_line && mpd && !sda_line) begin seg = 0; run = 1; hold_got = 1'b0; end
    mps = scl_line; mpd = sda_line;
  end

  task automatic push(input logic [10:0] w);
    cmd_word = w; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_abort();
    abort_clr = 1'b1; @(negedge clk); abort_clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp_rn = 0;
    int s0, p0, w0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(busy == 0 && en_status == 0 && cmd_ready == 0, "R9 idle flags", {busy, en_status, cmd_ready}, 0);
    check(abort_src == 0, "R9 abort", abort_src, 0);
    check(scl_line && sda_line, "R9 lines released", {scl_line, sda_line}, 2'b11);
    // R8 enable handshake
    enable_req = 1'b1;
    check(en_status == 0, "R8 not yet applied", en_status, 0);
    @(negedge clk);
    check(en_status == 1 && cmd_ready == 1, "R8 applied after one cycle", {en_status, cmd_ready}, 2'b11);

    for (int sp = 0; sp < 2; sp++) begin
      for (int n = 1; n <= 3; n++) begin
        fast_mode = sp[0];
        s0 = start_cnt; p0 = stop_cnt; w0 = wn;
        for (int i = 0; i < n; i++)
          push((i == n - 1 ? 11'h200 : 11'h000) | 11'(8'h40 + 16 * n + 8 * sp + i));
        wait_idle();
        // R1 R2 R4: n bytes in one transaction
        check(wn - w0 == n, "R2 bytes written", wn - w0, n);
        for (int i = 0; i < n; i++)
          check(wlog[w0 + i] == 8'(8'h40 + 16 * n + 8 * sp + i), "R1 write data", wlog[w0 + i], 8'h40 + 16 * n + 8 * sp + i);
        check(start_cnt - s0 == 1 && stop_cnt - p0 == 1, "R4 single transaction", start_cnt - s0, 1);
        check(abort_src == 0, "R2 no abort", abort_src, 0);
        // R6 R7 timing
        check(wseg[1] == (sp ? FL : SL), "R6 SCL low width", wseg[1], sp ? FL : SL);
        check(wseg[2] == (sp ? FH : SH), "R6 SCL high width", wseg[2], sp ? FH : SH);
        check(hold_meas == (sp ? FD : SD) + 1, "R7 SDA hold", hold_meas, (sp ? FD : SD) + 1);
        // R3 R5: write pointer then restart and read n bytes
        s0 = start_cnt; r0 = rcv;
        push(11'h001);
        for (int i = 0; i < n; i++)
          push(11'h100 | (i == 0 ? 11'h400 : 11'h000) | (i == n - 1 ? 11'h200 : 11'h000));
        wait_idle();
        check(start_cnt - s0 == 2, "R5 repeated start", start_cnt - s0, 2);
        check(rcv - r0 == n, "R3 bytes received", rcv - r0, n);
        for (int i = 0; i < n; i++) begin
          check(rlog[r0 + i] == pat(exp_rn), "R3 read data", rlog[r0 + i], pat(exp_rn));
          check(mack[exp_rn] == (i == n - 1), "R3 ack/nack", mack[exp_rn], i == n - 1);
          exp_rn++;
        end
      end
    end

    // R4 bus hold and R8 deferred disable
    fast_mode = 1'b0;
    s0 = start_cnt; p0 = stop_cnt; w0 = wn;
    push(11'h033);
    repeat (200) @(negedge clk);
    check(busy == 1 && scl_line == 0, "R4 bus held", {busy, scl_line}, 2'b10);
    check(stop_cnt == p0, "R4 no stop while held", stop_cnt - p0, 0);
    enable_req = 1'b0;
    repeat (3) @(negedge clk);
    check(en_status == 1, "R8 disable deferred", en_status, 1);
    push(11'h244);
    wait_idle();
    check(wn - w0 == 2 && wlog[w0] == 8'h33 && wlog[w0 + 1] == 8'h44, "R4 continued bytes", wlog[w0 + 1], 8'h44);
    check(start_cnt - s0 == 1, "R4 one start", start_cnt - s0, 1);
    check(en_status == 0 && cmd_ready == 0, "R8 disable applied", {en_status, cmd_ready}, 0);
    enable_req = 1'b1;
    repeat (2) @(negedge clk);

    // R3 receive backpressure
    rx_ready = 1'b0; r0 = rcv;
    push(11'h300);
    wait_idle();
    repeat (20) @(negedge clk);
    check(rx_valid == 1 && rx_data == pat(exp_rn), "R3 held under backpressure", rx_data, pat(exp_rn));
    check(mack[exp_rn] == 1, "R3 nack with stop", mack[exp_rn], 1);
    rx_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(rcv - r0 == 1 && rlog[r0] == pat(exp_rn), "R3 delivered once", rcv - r0, 1);
    exp_rn++;

    // R10 address nack
    target_addr = 7'h33; p0 = stop_cnt; w0 = wn;
    push(11'h277);
    wait_idle();
    check(abort_src == 13'h001, "R10 address nack bit", abort_src, 13'h001);
    check(stop_cnt - p0 == 1 && wn == w0, "R10 stop after address nack", stop_cnt - p0, 1);

    // R12 flush while abort held
    s0 = start_cnt;
    push(11'h211);
    push(11'h212);
    repeat (100) @(negedge clk);
    check(busy == 0 && start_cnt == s0 && scl_line == 1, "R12 commands discarded", start_cnt - s0, 0);
    check(abort_src == 13'h001, "R12 vector sticky", abort_src, 13'h001);
    clear_abort();
    check(abort_src == 0, "R12 cleared", abort_src, 0);
    target_addr = SLV;

    // R10 data nack
    p0 = stop_cnt;
    push(11'h2EE);
    wait_idle();
    check(abort_src == 13'h008, "R10 data nack bit", abort_src, 13'h008);
    check(stop_cnt - p0 == 1, "R10 stop after data nack", stop_cnt - p0, 1);
    clear_abort();

    // R11 arbitration loss
    push(11'h255);
    jam = 1'b1;
    for (int k = 0; k < 300 && !abort_src[12]; k++) @(negedge clk);
    @(negedge clk);
    check(abort_src == 13'h1000, "R11 arbitration bit", abort_src, 13'h1000);
    check(busy == 0 && scl_line == 1 && sda_oe == 0, "R11 lines released", {busy, scl_line, sda_oe}, 3'b010);
    jam = 1'b0;
    repeat (4) @(negedge clk);
    clear_abort();

    // R2 normal operation resumes
    w0 = wn;
    push(11'h25A);
    wait_idle();
    check(wn - w0 == 1 && wlog[w0] == 8'h5A && abort_src == 0, "R2 write after recovery", wlog[w0], 8'h5A);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule